// File: doc/BRIEF.md
# Four-Channel PWM Control and Status Word

This block holds the single 16-bit control and status word of a four-channel PWM timer unit. For every channel the word carries a run enable, a clock-rate choice, an interrupt enable and an interrupt pending flag. The word sits on a simple synchronous peripheral bus. A normal write replaces the whole word. Two further write-only addresses let software set or clear chosen bits in one write, with no read-modify-write sequence.

The block turns the run and rate bits into a per-channel count enable for the timers. A channel on the fast rate counts on every system clock. A channel on the slow rate counts once every 64 system clocks, through a free-running prescale pulse, so the whole unit stays on one clock. Each timer reports its events to the block as single-cycle pulses. An event latches the channel's pending flag, and the flag stays set until software clears it. A single registered interrupt line is raised while any channel has both its enable and its pending flag set. Because all four run bits sit in one field, one write can start or stop every timer at once.

Top module: `pwm_ctrl_bank`

## Requirements
- R1: After reset the word reads 0x0000, `irq_o` is 0, `run_o` is 0 and `tick_en_o` is 0.
- R2: A write to offset 0x00 replaces the whole word, and a read of offset 0x00 returns it. The field layout is: bits 3:0 run, bits 7:4 slow-rate select, bits 11:8 interrupt enable and bits 15:12 pending, with bit n of each field belonging to channel n.
- R3: A write to offset 0x02 ORs the write data into the word. A read of 0x02 returns 0.
- R4: A write to offset 0x04 clears every bit of the word that is written as 1 and leaves the other bits alone. A read of 0x04 returns 0.
- R5: A one-cycle pulse on `chan_event[n]` sets pending bit 12+n. The bit stays set after the pulse ends and falls only on a software write to 0x00 or 0x04.
- R6: When an event pulse and a clear write (0x04) hit the same pending bit in the same cycle, the bit ends set.
- R7: `irq_o` is 1 exactly one cycle after the word holds some channel n with enable bit 8+n and pending bit 12+n both set, and is 0 otherwise.
- R8: `run_o[n]` follows word bit n. `tick_en_o[n]` is 0 whenever `run_o[n]` is 0.
- R9: A running channel with slow-rate bit 4+n at 0 has `tick_en_o[n]` high on every cycle. With that bit at 1, it is high on one cycle in every 64, and its pulses are 64 cycles apart.
- R10: Writes to any offset other than 0x00, 0x02 and 0x04 leave the word unchanged. Reads of such offsets return 0.
- R11: A single write to 0x00 starts all four channels (run field 0xF) or stops all four (run field 0x0) together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 8 | Byte offset within the unit |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational, 0 when not reading the word |
| chan_event | input | 4 | One-cycle event pulse per channel from the timers |
| run_o | output | 4 | Per-channel run enable |
| slow_sel_o | output | 4 | Per-channel slow-rate select |
| tick_en_o | output | 4 | Per-channel count enable for the timers |
| irq_o | output | 1 | Registered combined interrupt request |

## Verification
The hardest case to reach from the ports is a timer event and a software clear landing on the same pending bit in the same clock edge. The bench reaches it by holding `chan_event` high across exactly the cycle in which it drives a clear-alias write of that bit, then reading the word back. The slow-rate spacing is the other case that needs care, because the prescale counter runs free from reset. The bench does not predict the phase. It records the cycle of each count enable pulse over a long window and checks the count of pulses and the spacing between them.

// File: rtl/pwm_ctrl_pkg.sv
// Package: shared sizes, bus offsets and field positions of the PWM
// control word. Assumes one bit per channel in each of four fields.
package pwm_ctrl_pkg;

    localparam int CH_N     = 4;            // channels in the unit
    localparam int FIELDS   = 4;            // run, slow, enable, pending
    localparam int WORD_W   = CH_N * FIELDS;
    localparam int ADDR_W   = 8;
    localparam int PRESCALE = 64;           // slow-rate divider

    // Field base bit positions inside the word (decoded by the timers).
    localparam int RUN_LSB  = 0;
    localparam int SLOW_LSB = CH_N;
    localparam int IEN_LSB  = 2 * CH_N;
    localparam int PEND_LSB = 3 * CH_N;

    // Bus offsets of the word and its write-only aliases.
    localparam logic [ADDR_W-1:0] OFS_WORD = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_SET  = 8'h02;
    localparam logic [ADDR_W-1:0] OFS_CLR  = 8'h04;

    // Kind of software update applied to the word in one cycle.
    typedef enum logic [1:0] {
        UPD_NONE  = 2'd0,
        UPD_WRITE = 2'd1,
        UPD_SET   = 2'd2,
        UPD_CLR   = 2'd3
    } upd_kind_e;

endpackage

// File: rtl/pwm_bus_decode.sv
// Module: decodes one bus access into the kind of word update and a
// read-select for the word. Assumes single-cycle accesses qualified by
// sel; unmapped offsets decode to no update and no read.
module pwm_bus_decode
    import pwm_ctrl_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          sel_i,
    input  logic          wr_i,
    input  logic [AW-1:0] addr_i,
    output upd_kind_e     upd_o,
    output logic          rd_word_o
);

    logic hit_word;
    logic hit_set;
    logic hit_clr;

    // Address match against the three mapped offsets.
    always_comb begin
        hit_word = (addr_i == AW'(OFS_WORD));
        hit_set  = (addr_i == AW'(OFS_SET));
        hit_clr  = (addr_i == AW'(OFS_CLR));
    end

    // Select the update kind for writes; aliases never select a read.
    always_comb begin
        upd_o = UPD_NONE;
        if (sel_i && wr_i) begin
            if (hit_word)     upd_o = UPD_WRITE;
            else if (hit_set) upd_o = UPD_SET;
            else if (hit_clr) upd_o = UPD_CLR;
        end
        rd_word_o = sel_i && !wr_i && hit_word;
    end

endmodule

// File: rtl/pwm_word_reg.sv
// Module: the control word itself. Applies one software update per
// cycle, then ORs in the hardware event pulses on the pending field so
// that an event arriving with a clear always leaves its flag set.
module pwm_word_reg
    import pwm_ctrl_pkg::*;
#(
    parameter int NUM_CH = CH_N,
    localparam int W     = NUM_CH * FIELDS,
    localparam int P_LSB = 3 * NUM_CH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  upd_kind_e         upd_i,
    input  logic [W-1:0]      wdata_i,
    input  logic [NUM_CH-1:0] event_i,
    output logic [W-1:0]      word_o
);

    logic [W-1:0] word_q;
    logic [W-1:0] sw_next;
    logic [W-1:0] hw_set;
    logic [W-1:0] word_d;

    // Software view of the next word value.
    always_comb begin
        unique case (upd_i)
            UPD_WRITE: sw_next = wdata_i;
            UPD_SET:   sw_next = word_q | wdata_i;
            UPD_CLR:   sw_next = word_q & ~wdata_i;
            default:   sw_next = word_q;
        endcase
    end

    // Event pulses placed on the pending field, applied after software.
    always_comb begin
        hw_set = '0;
        hw_set[P_LSB +: NUM_CH] = event_i;
        word_d = sw_next | hw_set;
    end

    // Word storage with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
    end

    assign word_o = word_q;

endmodule

// File: rtl/pwm_tick_gen.sv
// Module: free-running prescaler and per-channel count enables. Assumes
// the slow rate is a one-cycle pulse every PRESCALE clocks, not a clock.
module pwm_tick_gen #(
    parameter int NUM_CH   = 4,
    parameter int PRESCALE = 64,
    localparam int PS_W    = (PRESCALE > 1) ? $clog2(PRESCALE) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] run_i,
    input  logic [NUM_CH-1:0] slow_i,
    output logic [NUM_CH-1:0] tick_en_o
);

    logic [PS_W-1:0] ps_cnt_q;
    logic            ps_pulse;

    assign ps_pulse = (ps_cnt_q == PS_W'(PRESCALE - 1));

    // Prescale counter wrapping at PRESCALE-1.
    always_ff @(posedge clk) begin
        if (!rst_n)        ps_cnt_q <= '0;
        else if (ps_pulse) ps_cnt_q <= '0;
        else               ps_cnt_q <= ps_cnt_q + 1'b1;
    end

    // Per-channel gate: stopped channels never tick.
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_gate
        assign tick_en_o[ch] = run_i[ch] & (slow_i[ch] ? ps_pulse : 1'b1);
    end

endmodule

// File: rtl/pwm_irq_gen.sv
// Module: combined interrupt request. A channel requests when its
// enable and pending bits are both set; the OR is registered once.
module pwm_irq_gen #(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] ien_i,
    input  logic [NUM_CH-1:0] pend_i,
    output logic              irq_o
);

    logic irq_q;

    // Register the OR of enabled pending flags.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(ien_i & pend_i);
    end

    assign irq_o = irq_q;

endmodule

// File: rtl/pwm_ctrl_bank.sv
// Module: top of the PWM control word block. Decodes the bus, holds the
// word, drives run/rate/count-enable outputs and the interrupt line.
// Assumes a single clock and synchronous active-low reset.
module pwm_ctrl_bank
    import pwm_ctrl_pkg::*;
#(
    parameter int NUM_CH   = CH_N,
    parameter int AW       = ADDR_W,
    parameter int PS_DIV   = PRESCALE,
    localparam int W       = NUM_CH * FIELDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [AW-1:0]     bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [NUM_CH-1:0] chan_event,
    output logic [NUM_CH-1:0] run_o,
    output logic [NUM_CH-1:0] slow_sel_o,
    output logic [NUM_CH-1:0] tick_en_o,
    output logic              irq_o
);

    upd_kind_e    upd;
    logic         rd_word;
    logic [W-1:0] ctrl_q;

    pwm_bus_decode #(.AW(AW)) u_dec (
        .sel_i     (bus_sel),
        .wr_i      (bus_wr),
        .addr_i    (bus_addr),
        .upd_o     (upd),
        .rd_word_o (rd_word)
    );

    pwm_word_reg #(.NUM_CH(NUM_CH)) u_word (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd_i   (upd),
        .wdata_i (bus_wdata),
        .event_i (chan_event),
        .word_o  (ctrl_q)
    );

    // Split the word into its per-channel fields.
    assign run_o      = ctrl_q[0          +: NUM_CH];
    assign slow_sel_o = ctrl_q[NUM_CH     +: NUM_CH];

    pwm_tick_gen #(.NUM_CH(NUM_CH), .PRESCALE(PS_DIV)) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run_o),
        .slow_i    (slow_sel_o),
        .tick_en_o (tick_en_o)
    );

    pwm_irq_gen #(.NUM_CH(NUM_CH)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .ien_i  (ctrl_q[2*NUM_CH +: NUM_CH]),
        .pend_i (ctrl_q[3*NUM_CH +: NUM_CH]),
        .irq_o  (irq_o)
    );

    // Read mux: only the word offset returns data.
    assign bus_rdata = rd_word ? ctrl_q : '0;

endmodule

// File: rtl/pwm_ctrl_bank_chk.sv
// Module: assertion checker bound to pwm_ctrl_bank. Relates bus
// accesses, event pulses, the word and the outputs over time.
module pwm_ctrl_bank_chk
    import pwm_ctrl_pkg::*;
#(
    parameter int NUM_CH = CH_N,
    parameter int AW     = ADDR_W,
    localparam int W     = NUM_CH * FIELDS
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [AW-1:0]     bus_addr,
    input logic [W-1:0]      bus_rdata,
    input logic [NUM_CH-1:0] chan_event,
    input logic [NUM_CH-1:0] run_o,
    input logic [NUM_CH-1:0] tick_en_o,
    input logic              irq_o,
    input logic [W-1:0]      ctrl_q
);

    logic [NUM_CH-1:0] pend;
    logic [NUM_CH-1:0] ien;
    logic              clr_wr;
    logic              past_ok;

    assign pend   = ctrl_q[3*NUM_CH +: NUM_CH];
    assign ien    = ctrl_q[2*NUM_CH +: NUM_CH];
    assign clr_wr = bus_sel && bus_wr &&
                    (bus_addr == AW'(OFS_WORD) || bus_addr == AW'(OFS_CLR));

    // Marks that at least one clock has passed since reset release.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    a_r3_alias_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && (bus_addr == AW'(OFS_SET) || bus_addr == AW'(OFS_CLR)))
        |-> (bus_rdata == '0));

    a_r5_pend_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && (($past(pend) & ~pend) != '0)) |-> $past(clr_wr));

    a_r6_event_sets_pend: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_event != '0) |=> ((pend & $past(chan_event)) == $past(chan_event)));

    a_r7_irq_registered: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (irq_o == $past(|(ien & pend))));

    a_r8_no_tick_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        ((tick_en_o & ~run_o) == '0));

endmodule

bind pwm_ctrl_bank pwm_ctrl_bank_chk #(.NUM_CH(NUM_CH), .AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .chan_event (chan_event),
    .run_o      (run_o),
    .tick_en_o  (tick_en_o),
    .irq_o      (irq_o),
    .ctrl_q     (ctrl_q)
);

// File: tb/pwm_ctrl_bank_test.sv
// Bench: directed tests of pwm_ctrl_bank, one task per scenario.
module pwm_ctrl_bank_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [3:0]  chan_event = '0;
    logic [3:0]  run_o;
    logic [3:0]  slow_sel_o;
    logic [3:0]  tick_en_o;
    logic        irq_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pwm_ctrl_bank uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .chan_event (chan_event),
        .run_o      (run_o),
        .slow_sel_o (slow_sel_o),
        .tick_en_o  (tick_en_o),
        .irq_o      (irq_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Writes take effect at the next posedge; returns at the following negedge.
    task automatic bus_write(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    // Combinational read sampled mid-cycle.
    task automatic bus_read(input logic [7:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic pulse_event(input logic [3:0] ev);
        @(negedge clk);
        chan_event = ev;
        @(negedge clk);
        chan_event = '0;
    endtask

    task automatic t_reset;
        logic [15:0] d;
        check("R1 irq after reset", irq_o, 0);
        check("R1 run after reset", run_o, 0);
        check("R1 tick after reset", tick_en_o, 0);
        bus_read(8'h00, d);
        check("R1 word after reset", d, 16'h0000);
    endtask

    task automatic t_write_read;
        logic [15:0] d;
        bus_write(8'h00, 16'h0A5C);
        bus_read(8'h00, d);
        check("R2 readback", d, 16'h0A5C);
        check("R8 run follows bits 3:0", run_o, 4'hC);
        check("R2 slow field bits 7:4", slow_sel_o, 4'h5);
        bus_write(8'h00, 16'h0000);
    endtask

    task automatic t_set_clear;
        logic [15:0] d;
        bus_write(8'h00, 16'h0030);
        bus_write(8'h02, 16'h0201);
        bus_read(8'h00, d);
        check("R3 set alias ORs", d, 16'h0231);
        bus_read(8'h02, d);
        check("R3 set alias reads 0", d, 16'h0000);
        bus_write(8'h04, 16'h0011);
        bus_read(8'h00, d);
        check("R4 clear alias", d, 16'h0220);
        bus_read(8'h04, d);
        check("R4 clear alias reads 0", d, 16'h0000);
        bus_write(8'h00, 16'h0000);
    endtask

    task automatic t_event_sticky;
        logic [15:0] d;
        pulse_event(4'b0100);
        repeat (3) @(negedge clk);
        bus_read(8'h00, d);
        check("R5 pending sticky", d, 16'h4000);
        bus_write(8'h02, 16'h0010);
        bus_read(8'h00, d);
        check("R5 pending kept by set alias", d, 16'h4010);
        bus_write(8'h04, 16'h4000);
        bus_read(8'h00, d);
        check("R5 pending cleared by alias", d, 16'h0010);
        bus_write(8'h00, 16'h0000);
    endtask

    task automatic t_clash;
        logic [15:0] d;
        bus_write(8'h00, 16'h1000);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h04; bus_wdata = 16'h3000;
        chan_event = 4'b0001;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0; chan_event = '0;
        bus_read(8'h00, d);
        check("R6 event beats clear", d, 16'h1000);
        bus_write(8'h00, 16'h0000);
    endtask

    task automatic t_irq;
        bus_write(8'h00, 16'h0200);
        @(negedge clk);
        check("R7 enable alone no irq", irq_o, 0);
        @(negedge clk);
        chan_event = 4'b0010;
        @(negedge clk);
        chan_event = '0;
        check("R7 irq not yet", irq_o, 0);
        @(negedge clk);
        check("R7 irq one cycle later", irq_o, 1);
        bus_write(8'h04, 16'h0200);
        check("R7 irq still registered", irq_o, 1);
        @(negedge clk);
        check("R7 irq drops", irq_o, 0);
        bus_write(8'h00, 16'h0000);
    endtask

    task automatic t_rates;
        int n0;
        int first;
        int second;
        int n1;
        bus_write(8'h00, 16'h0013);
        n0 = 0; n1 = 0; first = -1; second = -1;
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            if (tick_en_o[0]) begin
                n0++;
                if (first < 0) first = i;
                else if (second < 0) second = i;
            end
            if (tick_en_o[1]) n1++;
        end
        check("R9 slow pulses in 256", n0, 4);
        check("R9 slow spacing", second - first, 64);
        check("R9 fast every cycle", n1, 256);
        check("R8 stopped channel silent", tick_en_o[3:2], 0);
        bus_write(8'h00, 16'h0000);
    endtask

    task automatic t_unmapped;
        logic [15:0] d;
        bus_write(8'h00, 16'h0F0A);
        bus_write(8'h06, 16'hFFFF);
        bus_write(8'h10, 16'h0000);
        bus_read(8'h00, d);
        check("R10 unmapped writes ignored", d, 16'h0F0A);
        bus_read(8'h06, d);
        check("R10 unmapped read zero", d, 16'h0000);
        bus_write(8'h00, 16'h0000);
    endtask

    task automatic t_all_run;
        bus_write(8'h00, 16'h000F);
        check("R11 all start", run_o, 4'hF);
        check("R11 all ticking", tick_en_o, 4'hF);
        bus_write(8'h00, 16'h0000);
        check("R11 all stop", run_o, 4'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_read();
        t_set_clear();
        t_event_sticky();
        t_clash();
        t_irq();
        t_rates();
        t_unmapped();
        t_all_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule